// File: doc/BRIEF.md
# Deferred SDRAM Refresh Scheduler

This block decides when an SDRAM controller spends time on auto-refresh commands. The refreshes are not forced onto a fixed tick. A free-running interval timer adds one owed refresh to a debt counter every `INTERVAL` clocks. With the default of 512 clocks, which is below the 781-cycle average that 8192 rows in 64 ms need at 100 MHz, the memory stays ahead of its retention limit. The debt grows while the controller runs long bursts, so a full page of 2048 column accesses is never split. It is paid back in a back-to-back batch as soon as the controller reports idle.

The request output and the acknowledge input follow valid/ready rules. Once `refresh_req` is raised it stays high until the cycle in which `refresh_ack` is sampled high; that cycle transfers one refresh. An acknowledge while no request is pending is ignored. After each transfer the request stays low for `TRC` clocks, which is the refresh cycle time of the memory. A request is raised only while `ctrl_idle` is high. It is not withdrawn if idle drops, so the controller must not start a burst while a request is waiting. `refresh_urgent` tells the controller to finish its current burst and to start no new one until the debt has fallen again.

Top module: `refresh_debt_sched`

## Requirements
- R1: After reset `refresh_req` and `refresh_urgent` are low. The debt and the interval timer are zero, so no request is raised before the first timer expiry. With the default parameters the request is still low 512 clocks after reset release.
- R2: Every `INTERVAL` clocks, counted from reset release, the debt rises by one. With the controller busy for 2100 clocks, the following idle window issues exactly 4 refreshes.
- R3: `refresh_req` rises only in the cycle after a cycle in which `ctrl_idle` was high, the debt was non-zero and no spacing gap was running. While the controller stays idle and debt remains, requests keep coming.
- R4: While `refresh_req` is high and `refresh_ack` is low, the request stays high in the next cycle.
- R5: A cycle with both `refresh_req` and `refresh_ack` high decrements the debt by one. `refresh_ack` while `refresh_req` is low has no effect on the debt.
- R6: After an accepted acknowledge, `refresh_req` is low for exactly `TRC` cycles (default 7) before it can rise again.
- R7: If a timer expiry and an accepted acknowledge fall in the same cycle, the debt is unchanged.
- R8: `refresh_urgent` is high exactly while the debt is at least `URGENT_LVL` (default 8).
- R9: The debt saturates at 2^`DEBT_W`−1 (default 15) and never wraps. A busy time of 16 intervals therefore leaves exactly 15 refreshes to be issued.
- R10: While the controller idles, the debt is paid back in full. At the end of every idle window the issued refreshes trail the elapsed intervals by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_idle | input | 1 | High while the controller runs no burst |
| refresh_ack | input | 1 | Controller accepts the pending refresh request |
| refresh_req | output | 1 | One refresh command wanted (valid) |
| refresh_urgent | output | 1 | Debt has reached the urgent threshold |

## Verification
On every cycle the assertions check the handshake rules: a request is held until it is acknowledged, it rises only after an idle cycle, and it stays low through the spacing gap. They also check that the debt moves by at most one step per clock, that saturation holds, that the urgent flag rises only when the debt crosses its threshold, and that no request exists with zero debt. Some behaviour shows only in the bench's directed and random scenarios, which drain the debt and count the refreshes that come out. These cover the exact number of refreshes owed after a busy period, loss-free handling of a timer expiry that coincides with an acknowledge, stray acknowledges having no effect, saturation at 15, and the bound on how far issued refreshes lag the elapsed intervals.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [1:0] {
    RQ_WAIT = 2'd0,
    RQ_ASK  = 2'd1,
    RQ_GAP  = 2'd2
  } rq_state_t;
endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
  parameter int INTERVAL = 512
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam bit POW2 = ((INTERVAL & (INTERVAL - 1)) == 0);

  logic [TW-1:0] cnt_q;

  generate
    if (POW2) begin : g_wrap
      assign tick = &cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_cmp
      localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);
      assign tick = (cnt_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
  parameter int DEBT_W     = 4,
  parameter int URGENT_LVL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              take,
  output logic [DEBT_W-1:0] debt,
  output logic              urgent
);
  localparam logic [DEBT_W-1:0] DMAX = {DEBT_W{1'b1}};
  localparam logic [DEBT_W-1:0] ULVL = DEBT_W'(URGENT_LVL);

  logic [DEBT_W-1:0] debt_q;
  logic [DEBT_W-1:0] debt_d;

  always_comb begin
    debt_d = debt_q;
    if (tick && !take) begin
      if (debt_q != DMAX) debt_d = debt_q + 1'b1;
    end else if (take && !tick) begin
      if (debt_q != '0) debt_d = debt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end

  assign debt   = debt_q;
  assign urgent = (debt_q >= ULVL);
endmodule

// File: rtl/refsched_issuer.sv
module refsched_issuer
  import refsched_pkg::*;
#(
  parameter int TRC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic debt_nz,
  input  logic ack,
  output logic req,
  output logic take
);
  localparam int GW = (TRC > 1) ? $clog2(TRC) : 1;
  localparam logic [GW-1:0] GLOAD = GW'(TRC - 1);

  rq_state_t     st_q;
  rq_state_t     st_d;
  logic [GW-1:0] gap_q;
  logic [GW-1:0] gap_d;

  assign req  = (st_q == RQ_ASK);
  assign take = req && ack;

  always_comb begin
    st_d  = st_q;
    gap_d = gap_q;
    unique case (st_q)
      RQ_WAIT: if (idle && debt_nz) st_d = RQ_ASK;
      RQ_ASK: begin
        if (ack) begin
          st_d  = RQ_GAP;
          gap_d = GLOAD;
        end
      end
      RQ_GAP: begin
        if (gap_q != '0)           gap_d = gap_q - 1'b1;
        else if (idle && debt_nz)  st_d  = RQ_ASK;
        else                       st_d  = RQ_WAIT;
      end
      default: st_d = RQ_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RQ_WAIT;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      gap_q <= gap_d;
    end
  end
endmodule

// File: rtl/refresh_debt_sched.sv
module refresh_debt_sched #(
  parameter int INTERVAL   = 512,
  parameter int TRC        = 7,
  parameter int URGENT_LVL = 8,
  parameter int DEBT_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_idle,
  input  logic refresh_ack,
  output logic refresh_req,
  output logic refresh_urgent
);
  logic              tick;
  logic              take;
  logic [DEBT_W-1:0] debt_q;

  refsched_interval #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  refsched_debt #(.DEBT_W(DEBT_W), .URGENT_LVL(URGENT_LVL)) u_debt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .take   (take),
    .debt   (debt_q),
    .urgent (refresh_urgent)
  );

  refsched_issuer #(.TRC(TRC)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (ctrl_idle),
    .debt_nz (debt_q != '0),
    .ack     (refresh_ack),
    .req     (refresh_req),
    .take    (take)
  );
endmodule

// File: rtl/refsched_checker.sv
module refsched_checker #(
  parameter int TRC        = 7,
  parameter int URGENT_LVL = 8,
  parameter int DEBT_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_idle,
  input logic              refresh_ack,
  input logic              refresh_req,
  input logic              refresh_urgent,
  input logic [DEBT_W-1:0] debt
);
  localparam int CW = $clog2(TRC + 1);
  localparam logic [DEBT_W-1:0] DMAX = {DEBT_W{1'b1}};
  localparam logic [DEBT_W-1:0] ULVL = DEBT_W'(URGENT_LVL);

  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap_cnt <= '0;
    else if (refresh_req && refresh_ack) gap_cnt <= CW'(TRC);
    else if (gap_cnt != '0)              gap_cnt <= gap_cnt - 1'b1;
  end

  assert_req_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_req) |-> $past(ctrl_idle));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);

  assert_no_req_without_debt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> (debt != '0));

  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt != '0) |-> !refresh_req);

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (debt != $past(debt)) |->
      (({1'b0, debt} == {1'b0, $past(debt)} + 1'b1) ||
       ({1'b0, debt} + 1'b1 == {1'b0, $past(debt)})));

  assert_urgent_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_urgent) |-> ($past(debt) == ULVL - 1'b1));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (debt == DMAX) |=> (debt >= DMAX - 1'b1));
endmodule

bind refresh_debt_sched refsched_checker #(
  .TRC(TRC), .URGENT_LVL(URGENT_LVL), .DEBT_W(DEBT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctrl_idle      (ctrl_idle),
  .refresh_ack    (refresh_ack),
  .refresh_req    (refresh_req),
  .refresh_urgent (refresh_urgent),
  .debt           (debt_q)
);

// File: tb/tb_refresh_debt_sched.sv
`timescale 1ns/1ps
module tb_refresh_debt_sched;
  localparam int INTERVAL = 512;
  localparam int TRC      = 7;
  localparam int ULVL     = 8;
  localparam int DMAX     = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_idle = 1'b0;
  logic refresh_ack = 1'b0;
  logic refresh_req;
  logic refresh_urgent;

  int checks = 0, failures = 0;
  int tcnt, exp_debt, gapm, ticks, acks, win_acks, ack_mode;
  bit prev_req, prev_accept, prev_should, want_idle, done;

  always #2 clk = ~clk;

  refresh_debt_sched #(.INTERVAL(INTERVAL), .TRC(TRC), .URGENT_LVL(ULVL), .DEBT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_idle(ctrl_idle), .refresh_ack(refresh_ack),
    .refresh_req(refresh_req), .refresh_urgent(refresh_urgent));

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int next_debt(input int d, input bit tk, input bit acc);
    if (tk && !acc) return (d == DMAX) ? d : d + 1;
    if (acc && !tk) return (d == 0) ? 0 : d - 1;
    return d;
  endfunction

  task automatic body();
    bit accept, tk, should;
    if (prev_req && !prev_accept) chk("R4 request held", refresh_req, 1);
    else if (prev_accept)         chk("R6 gap after ack", refresh_req, 0);
    else                          chk("R3 request raise", refresh_req, int'(prev_should));
    chk("R8 urgent flag", refresh_urgent, int'(exp_debt >= ULVL));
    ctrl_idle = want_idle;
    if (refresh_req && want_idle) begin
      case (ack_mode)
        1:       refresh_ack = (tcnt == INTERVAL - 1);
        2:       refresh_ack = 1'b0;
        default: refresh_ack = ($urandom % 4 != 0);
      endcase
    end else if (!refresh_req) begin
      refresh_ack = ($urandom % 8 == 0);
    end else begin
      refresh_ack = 1'b0;
    end
    accept = refresh_req && refresh_ack;
    tk     = (tcnt == INTERVAL - 1);
    should = !refresh_req && want_idle && (exp_debt > 0) && (gapm <= 1);
    exp_debt = next_debt(exp_debt, tk, accept);
    tcnt = tk ? 0 : tcnt + 1;
    if (accept)        gapm = TRC;
    else if (gapm > 0) gapm = gapm - 1;
    if (tk) ticks++;
    if (accept) begin acks++; win_acks++; end
    prev_req = refresh_req; prev_accept = accept; prev_should = should;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      body();
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctrl_idle = 1'b0; refresh_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tcnt = 0; exp_debt = 0; gapm = 0; ticks = 0; acks = 0; win_acks = 0;
    prev_req = 0; prev_accept = 0; prev_should = 0; ack_mode = 0;
    chk("R1 reset request", refresh_req, 0);
    chk("R1 reset urgent", refresh_urgent, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1: idle from reset, no request before the first expiry
    want_idle = 1;
    do_reset();
    run(512);
    chk("R1 no request before first expiry", refresh_req, 0);
    run(300);
    chk("R10 lag after idle", int'((ticks - acks) <= 1), 1);

    // R2 / R5: busy for 2100 cycles with stray acks, then drain
    want_idle = 0;
    do_reset();
    run(2100);
    win_acks = 0; want_idle = 1;
    run(100);
    chk("R2 owed refreshes after busy burst", win_acks, 4);
    chk("R5 stray acks ignored", acks, 4);

    // R8 / R9: long busy period to saturation
    want_idle = 0;
    do_reset();
    run(3600);
    chk("R8 urgent low at 7 owed", refresh_urgent, 0);
    run(600);
    chk("R8 urgent high at 8 owed", refresh_urgent, 1);
    run(4002);
    chk("R9 urgent at saturation", refresh_urgent, 1);
    win_acks = 0; want_idle = 1;
    run(200);
    chk("R9 saturated drain count", win_acks, DMAX);
    chk("R8 urgent clear after drain", refresh_urgent, 0);

    // R7: acknowledge in the same cycle as a timer expiry
    want_idle = 1;
    do_reset();
    ack_mode = 1;
    run(1030);
    chk("R7 one collision ack", acks, 1);
    ack_mode = 0; win_acks = 0;
    run(200);
    chk("R7 debt kept across collision", win_acks, 1);

    // R3 / R10: random bursts, controller honours the urgent flag
    do_reset();
    for (int b = 0; b < 12; b++) begin
      int len;
      len = 200 + int'($urandom % 3000);
      want_idle = 0;
      for (int c = 0; c < len; c++) begin
        run(1);
        if (refresh_urgent) break;
      end
      want_idle = 1;
      run(300);
      chk("R10 issued refreshes lag intervals", int'((ticks - acks) <= 1), 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule